// File: doc/BRIEF.md
# Serial Canonical Huffman Symbol Decoder

This block turns a stream of entropy-coded bits, one bit per cycle, into 8-bit symbols. It uses canonical Huffman tables of the kind found in still-image compression. For every code length from 1 to 16 it holds three values: the largest code of that length, the smallest code of that length, and the position in the symbol list where that length's symbols begin. Beside these it keeps a list of up to 256 symbol values. Software or a preceding block loads all of these through a small write port before decoding starts.

Decoding grows a code one bit at a time. After each new bit, the code is compared with the largest code for its current length. When the code is no larger than that limit, the symbol list is read at the length's start position plus the code's distance above the length's smallest code. A code that reaches 16 bits without a match raises an error pulse, and the partial code is dropped.

The bit input is a valid/ready stream. A bit transfers on a rising edge where both `bit_valid` and `bit_ready` are high. The producer may hold `bit_valid` low for any number of cycles, and the decoder then waits with its partial code intact. The decoder drops `bit_ready` for exactly one cycle after the final bit of each code, while it forms the list index. A bit offered in that cycle is held by the producer and transfers in the next cycle. The symbol output is a one-cycle pulse with no back-pressure.

Top module: `serial_huff_decoder`

## Requirements
- R1: For each code, the symbol delivered is the list entry at index (start position of length L + code − smallest code of L) modulo 256. L is the first length, counting up from 1 with one more input bit each time, at which the code is no larger than that length's largest code. Code bits arrive most significant bit first.
- R2: A length marked empty (configuration kind 4) never matches, so decoding always continues to a longer code. A later write of kind 0 to that length clears the mark.
- R3: A bit is consumed only on an edge where `bit_valid` and `bit_ready` are both high. While `bit_valid` is low, the partial code and length are held, and no symbol or error is produced.
- R4: The final bit of a code is accepted on edge e. `bit_ready` is then low from edge e until edge e+1. `sym_valid` is high for exactly one cycle, beginning at edge e+1, and `bit_ready` is high again in that cycle.
- R5: When the 16th bit of a code does not produce a match, `dec_err` is high for one cycle, beginning at the edge that accepted that bit. No symbol is emitted for that code, and the next bit begins a new code.
- R6: A write occurs when `cfg_we` is high. The `cfg_kind` encodings are: 0 sets the largest code of a length and marks it non-empty; 1 sets the smallest code; 2 sets the start position, taken from `cfg_data[7:0]`; 3 writes symbol list entry `cfg_addr` with `cfg_data[7:0]`; 4 marks a length empty. For kinds 0, 1, 2 and 4, `cfg_addr` holds the length minus one (0 to 15). A write is applied only while no partial code is held and no symbol is being formed. At any other time it is ignored.
- R7: Synchronous active-high `rst` discards any partial code and clears `sym_valid` and `dec_err`, leaving `bit_ready` high. The tables keep their contents.
- R8: Codes of every length from 1 to 16 bits decode, including a 16-bit code whose first 15 bits are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Input bit is offered |
| bit_data | input | 1 | The offered code bit |
| bit_ready | output | 1 | Decoder can take a bit this cycle |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 3 | Which table a write targets (see R6) |
| cfg_addr | input | 8 | Length minus one, or symbol list index |
| cfg_data | input | 16 | Write data |
| sym_valid | output | 1 | One-cycle pulse: `sym_data` holds a decoded symbol |
| sym_data | output | 8 | Decoded symbol value |
| dec_err | output | 1 | One-cycle pulse: no code matched within 16 bits |

## Verification
A symbol becomes due one clock after the edge that accepted its final bit, and `bit_ready` is low in the cycle between those two edges. An error pulse becomes due on the very edge that accepted the unmatched 16th bit. The bench drives and samples on falling edges. It queues each expected symbol at the falling edge right after that final bit is accepted, and a monitor compares each `sym_valid` pulse against the head of that queue. The directed timing checks look at `bit_ready`, `sym_valid` and `dec_err` at the first and second falling edges after acceptance.

// File: rtl/shd_pkg.sv
`timescale 1ns/1ps
package shd_pkg;
  localparam int MAX_LEN    = 16;
  localparam int CODE_W     = 16;
  localparam int SYM_W      = 8;
  localparam int LIST_DEPTH = 256;

  typedef enum logic [2:0] {
    K_MAXCODE = 3'd0,
    K_MINCODE = 3'd1,
    K_VALPTR  = 3'd2,
    K_SYMBOL  = 3'd3,
    K_EMPTY   = 3'd4
  } cfg_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GROW = 2'd1,
    S_EMIT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/shd_len_table.sv
`timescale 1ns/1ps
module shd_len_table
  import shd_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CODE_W  = 16,
  parameter int PTR_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int LIDX_W = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  cfg_kind_e         wr_kind,
  input  logic [LIDX_W-1:0] wr_len_idx,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  look_len,
  output logic [CODE_W-1:0] look_max,
  output logic              look_empty,
  input  logic [LEN_W-1:0]  emit_len,
  output logic [CODE_W-1:0] emit_min,
  output logic [PTR_W-1:0]  emit_ptr
);
  logic [CODE_W-1:0] max_arr   [MAX_LEN];
  logic [CODE_W-1:0] min_arr   [MAX_LEN];
  logic [PTR_W-1:0]  ptr_arr   [MAX_LEN];
  logic              empty_arr [MAX_LEN];

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_len
    logic [CODE_W-1:0] max_r;
    logic [CODE_W-1:0] min_r;
    logic [PTR_W-1:0]  ptr_r;
    logic              empty_r;
    logic              sel;

    assign sel = wr_en && (wr_len_idx == LIDX_W'(g));

    always_ff @(posedge clk) begin
      if (sel) begin
        case (wr_kind)
          K_MAXCODE: begin
            max_r   <= wr_data;
            empty_r <= 1'b0;
          end
          K_MINCODE: min_r   <= wr_data;
          K_VALPTR:  ptr_r   <= wr_data[PTR_W-1:0];
          K_EMPTY:   empty_r <= 1'b1;
          default:   ;
        endcase
      end
    end

    assign max_arr[g]   = max_r;
    assign min_arr[g]   = min_r;
    assign ptr_arr[g]   = ptr_r;
    assign empty_arr[g] = empty_r;
  end

  // Lengths are 1-based on the read side; anything out of range reads empty.
  always_comb begin
    look_max   = '0;
    look_empty = 1'b1;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (look_len == LEN_W'(i + 1)) begin
        look_max   = max_arr[i];
        look_empty = empty_arr[i];
      end
    end
  end

  always_comb begin
    emit_min = '0;
    emit_ptr = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      if (emit_len == LEN_W'(i + 1)) begin
        emit_min = min_arr[i];
        emit_ptr = ptr_arr[i];
      end
    end
  end
endmodule

// File: rtl/shd_sym_store.sv
`timescale 1ns/1ps
module shd_sym_store #(
  parameter int DEPTH  = 256,
  parameter int SYM_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SYM_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SYM_W-1:0] rd_data
);
  logic [SYM_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/shd_engine.sv
`timescale 1ns/1ps
module shd_engine
  import shd_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CODE_W  = 16,
  parameter int SYM_W   = 8,
  parameter int IDX_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic [LEN_W-1:0]  look_len,
  input  logic [CODE_W-1:0] look_max,
  input  logic              look_empty,
  output logic [LEN_W-1:0]  emit_len,
  input  logic [CODE_W-1:0] emit_min,
  input  logic [IDX_W-1:0]  emit_ptr,
  output logic [IDX_W-1:0]  list_idx,
  input  logic [SYM_W-1:0]  list_data,
  output logic              sym_valid,
  output logic [SYM_W-1:0]  sym_data,
  output logic              dec_err,
  output logic              idle
);
  eng_state_e        state_q;
  logic [LEN_W-1:0]  len_q;
  logic [CODE_W-1:0] code_q;

  logic              accept;
  logic [LEN_W-1:0]  cand_len;
  logic [CODE_W-1:0] cand_code;
  logic              hit;
  logic              at_last_len;

  assign bit_ready   = (state_q != S_EMIT);
  assign idle        = (state_q == S_IDLE);
  assign accept      = bit_valid && bit_ready;

  // Candidate code: first bit starts fresh at length 1, later bits shift in.
  assign cand_len    = (state_q == S_IDLE) ? LEN_W'(1) : len_q + LEN_W'(1);
  assign cand_code   = (state_q == S_IDLE) ? CODE_W'(bit_data)
                                           : {code_q[CODE_W-2:0], bit_data};
  assign look_len    = cand_len;
  assign hit         = !look_empty && (cand_code <= look_max);
  assign at_last_len = (cand_len == LEN_W'(MAX_LEN));

  // Index formation for the held code, used during the emit cycle.
  assign emit_len    = len_q;
  assign list_idx    = IDX_W'(CODE_W'(emit_ptr) + code_q - emit_min);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      len_q     <= '0;
      code_q    <= '0;
      sym_valid <= 1'b0;
      sym_data  <= '0;
      dec_err   <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      dec_err   <= 1'b0;
      case (state_q)
        S_IDLE, S_GROW: begin
          if (accept) begin
            if (hit) begin
              code_q  <= cand_code;
              len_q   <= cand_len;
              state_q <= S_EMIT;
            end else if (at_last_len) begin
              code_q  <= '0;
              len_q   <= '0;
              dec_err <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              code_q  <= cand_code;
              len_q   <= cand_len;
              state_q <= S_GROW;
            end
          end
        end
        S_EMIT: begin
          sym_valid <= 1'b1;
          sym_data  <= list_data;
          code_q    <= '0;
          len_q     <= '0;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R4: symbol strobe lasts one cycle
  assert_sym_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> !sym_valid);

  // R4: a symbol follows a cycle in which input was refused
  assert_ready_gap_R4: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> !$past(bit_ready));

  // R5: error strobe lasts one cycle and never coincides with a symbol
  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    dec_err |=> !dec_err);

  assert_err_no_sym_R5: assert property (@(posedge clk) disable iff (rst)
    !(dec_err && sym_valid));

  // R5: an error only follows a code that had grown to one short of the limit
  assert_err_full_len_R5: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> ($past(len_q) == LEN_W'(MAX_LEN - 1)));

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (rst)
    len_q <= LEN_W'(MAX_LEN));

  // R2: an empty length never ends a code
  assert_empty_no_match_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && look_empty) |=> (state_q != S_EMIT));

  // R3: no valid bit means the partial code is held
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_EMIT && !bit_valid) |=> ($stable(len_q) && $stable(code_q)));
endmodule

// File: rtl/serial_huff_decoder.sv
`timescale 1ns/1ps
module serial_huff_decoder
  import shd_pkg::*;
#(
  parameter int MAX_LEN    = shd_pkg::MAX_LEN,
  parameter int CODE_W     = shd_pkg::CODE_W,
  parameter int SYM_W      = shd_pkg::SYM_W,
  parameter int LIST_DEPTH = shd_pkg::LIST_DEPTH,
  localparam int IDX_W     = $clog2(LIST_DEPTH),
  localparam int LIDX_W    = $clog2(MAX_LEN),
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [CODE_W-1:0] cfg_data,
  output logic              sym_valid,
  output logic [SYM_W-1:0]  sym_data,
  output logic              dec_err
);
  cfg_kind_e         kind;
  logic              eng_idle;
  logic              wr_ok;
  logic              len_wr;
  logic              sym_wr;
  logic [LEN_W-1:0]  look_len;
  logic [CODE_W-1:0] look_max;
  logic              look_empty;
  logic [LEN_W-1:0]  emit_len;
  logic [CODE_W-1:0] emit_min;
  logic [IDX_W-1:0]  emit_ptr;
  logic [IDX_W-1:0]  list_idx;
  logic [SYM_W-1:0]  list_data;

  assign kind   = cfg_kind_e'(cfg_kind);
  assign wr_ok  = cfg_we && eng_idle;
  assign sym_wr = wr_ok && (kind == K_SYMBOL);
  assign len_wr = wr_ok && (cfg_addr < IDX_W'(MAX_LEN)) &&
                  (kind == K_MAXCODE || kind == K_MINCODE ||
                   kind == K_VALPTR  || kind == K_EMPTY);

  shd_len_table #(
    .MAX_LEN (MAX_LEN),
    .CODE_W  (CODE_W),
    .PTR_W   (IDX_W)
  ) u_len (
    .clk        (clk),
    .wr_en      (len_wr),
    .wr_kind    (kind),
    .wr_len_idx (cfg_addr[LIDX_W-1:0]),
    .wr_data    (cfg_data),
    .look_len   (look_len),
    .look_max   (look_max),
    .look_empty (look_empty),
    .emit_len   (emit_len),
    .emit_min   (emit_min),
    .emit_ptr   (emit_ptr)
  );

  shd_sym_store #(
    .DEPTH (LIST_DEPTH),
    .SYM_W (SYM_W)
  ) u_sym (
    .clk     (clk),
    .wr_en   (sym_wr),
    .wr_idx  (cfg_addr),
    .wr_data (cfg_data[SYM_W-1:0]),
    .rd_idx  (list_idx),
    .rd_data (list_data)
  );

  shd_engine #(
    .MAX_LEN (MAX_LEN),
    .CODE_W  (CODE_W),
    .SYM_W   (SYM_W),
    .IDX_W   (IDX_W)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_ready  (bit_ready),
    .look_len   (look_len),
    .look_max   (look_max),
    .look_empty (look_empty),
    .emit_len   (emit_len),
    .emit_min   (emit_min),
    .emit_ptr   (emit_ptr),
    .list_idx   (list_idx),
    .list_data  (list_data),
    .sym_valid  (sym_valid),
    .sym_data   (sym_data),
    .dec_err    (dec_err),
    .idle       (eng_idle)
  );

  // R6: a table write is never taken while a code is in progress
  assert_write_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !eng_idle) |-> !(len_wr || sym_wr));
endmodule

// File: tb/sim_serial_huff_decoder.sv
`timescale 1ns/1ps
module sim_serial_huff_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        bit_valid, bit_data, bit_ready;
  logic        cfg_we;
  logic [2:0]  cfg_kind;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic        sym_valid, dec_err;
  logic [7:0]  sym_data;

  always #5 clk = ~clk;

  serial_huff_decoder u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sym_valid(sym_valid),
    .sym_data(sym_data), .dec_err(dec_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit err_allow = 1'b0;
  int exp_q[$];

  int cnt   [17];
  int maxc  [17];
  int minc  [17];
  int vptr  [17];
  bit emp   [17];
  int hcode [256];
  int hlen  [256];
  int hval  [256];
  int nsym;

  task automatic check(input bit ok, input string req, input int act,
                       input int expv, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Canonical code assignment from the per-length counts.
  function automatic void build_table();
    int code = 0;
    int k = 0;
    for (int l = 1; l <= 16; l++) begin
      vptr[l] = k;
      if (cnt[l] == 0) begin
        emp[l] = 1'b1; maxc[l] = 0; minc[l] = 0;
      end else begin
        emp[l] = 1'b0; minc[l] = code;
        for (int j = 0; j < cnt[l]; j++) begin
          hcode[k] = code; hlen[k] = l; k++; code++;
        end
        maxc[l] = code - 1;
      end
      code = code << 1;
    end
    nsym = k;
  endfunction

  task automatic cfg_write(input int kind, input int addr, input int data);
    cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_addr = 8'(addr); cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_table();
    for (int l = 1; l <= 16; l++) begin
      if (emp[l]) cfg_write(4, l - 1, 0);
      else begin
        cfg_write(0, l - 1, maxc[l]);
        cfg_write(1, l - 1, minc[l]);
        cfg_write(2, l - 1, vptr[l]);
      end
    end
    for (int k = 0; k < nsym; k++) begin
      hval[k] = int'($urandom % 256);
      cfg_write(3, k, hval[k]);
    end
  endtask

  // Offer one bit; returns at the falling edge after the edge that took it.
  task automatic send_bit(input bit b, input int gap);
    bit acc;
    for (int i = 0; i < gap; i++) begin
      bit_valid = 1'b0;
      @(negedge clk);
    end
    bit_valid = 1'b1; bit_data = b;
    do begin
      acc = bit_ready;
      @(negedge clk);
    end while (!acc);
    bit_valid = 1'b0;
  endtask

  task automatic send_range(input int k, input int from, input int upto,
                            input int maxgap);
    for (int i = from; i < upto; i++)
      send_bit(bit'((hcode[k] >> (hlen[k] - 1 - i)) & 1),
               maxgap > 0 ? int'($urandom % (maxgap + 1)) : 0);
  endtask

  task automatic send_sym(input int k, input int maxgap);
    send_range(k, 0, hlen[k], maxgap);
    exp_q.push_back(hval[k]);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0, "symbols still pending");
  endtask

  task automatic random_stream(input int n, input int maxgap);
    for (int i = 0; i < n; i++) send_sym(int'($urandom % nsym), maxgap);
    drain();
  endtask

  always @(negedge clk) begin
    int e;
    if (!rst) begin
      if (sym_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R1", sym_data, -1, "unexpected symbol");
        else begin
          e = exp_q.pop_front();
          check(sym_data == 8'(e), "R1", sym_data, e, "decoded symbol");
        end
      end
      if (dec_err && !err_allow) check(1'b0, "R5", 1, 0, "unexpected error pulse");
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k, seed, code, total, avail, c;
    seed = int'($urandom(32'h1d5e_0a11));
    rst = 1'b1; bit_valid = 1'b0; bit_data = 1'b0;
    cfg_we = 1'b0; cfg_kind = '0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    check(sym_valid == 1'b0, "R7", sym_valid, 0, "sym_valid in reset");
    check(dec_err == 1'b0, "R7", dec_err, 0, "dec_err in reset");
    check(bit_ready == 1'b1, "R7", bit_ready, 1, "bit_ready in reset");
    rst = 1'b0;
    @(negedge clk);

    // Table A: length 1 empty (R2), lengths 2..9 used.
    for (int l = 0; l <= 16; l++) cnt[l] = 0;
    cnt[2] = 1; cnt[3] = 5;
    for (int l = 4; l <= 9; l++) cnt[l] = 1;
    build_table();
    load_table();

    // R2: code "00" must not match at the empty length 1
    send_sym(0, 0);
    drain();

    // R4: exact handshake timing around the emit cycle
    k = nsym - 1;
    send_sym(k, 0);
    check(bit_ready == 1'b0, "R4", bit_ready, 0, "ready in emit cycle");
    check(sym_valid == 1'b0, "R4", sym_valid, 0, "valid in emit cycle");
    @(negedge clk);
    check(sym_valid == 1'b1, "R4", sym_valid, 1, "valid after emit");
    check(bit_ready == 1'b1, "R4", bit_ready, 1, "ready after emit");
    @(negedge clk);
    check(sym_valid == 1'b0, "R4", sym_valid, 0, "valid one cycle only");

    // R1: random symbols with random input gaps
    random_stream(200, 2);
    // R4: back-to-back offering, bit held across the refused cycle
    random_stream(60, 0);

    // R3: long stall mid-code
    send_range(k, 0, 2, 0);
    repeat (12) @(negedge clk);
    check(sym_valid == 1'b0, "R3", sym_valid, 0, "no symbol while stalled");
    check(bit_ready == 1'b1, "R3", bit_ready, 1, "ready while stalled");
    send_range(k, 2, hlen[k], 0);
    exp_q.push_back(hval[k]);
    drain();

    // R6: writes during a code are ignored
    send_range(k, 0, 1, 0);
    cfg_write(3, k, hval[k] ^ 8'hFF);
    cfg_write(0, hlen[k] - 1, 0);
    send_range(k, 1, hlen[k], 0);
    exp_q.push_back(hval[k]);
    drain();
    // R6: a write while idle takes effect
    hval[k] = hval[k] ^ 8'h5A;
    cfg_write(3, k, hval[k]);
    send_sym(k, 0);
    drain();

    // R7: reset mid-code drops the partial code, tables survive
    send_range(k, 0, 3, 0);
    rst = 1'b1;
    @(negedge clk);
    check(bit_ready == 1'b1, "R7", bit_ready, 1, "ready after mid-code reset");
    check(sym_valid == 1'b0, "R7", sym_valid, 0, "valid after mid-code reset");
    rst = 1'b0;
    @(negedge clk);
    send_sym(2, 0);
    send_sym(k, 1);
    drain();

    // Table B: one code at every length 1..16 (R8)
    for (int l = 1; l <= 16; l++) cnt[l] = 1;
    build_table();
    load_table();
    send_sym(15, 0);
    drain();
    random_stream(100, 1);

    // R5: sixteen ones match nothing
    err_allow = 1'b1;
    for (int i = 0; i < 16; i++) send_bit(1'b1, 0);
    check(dec_err == 1'b1, "R5", dec_err, 1, "error after 16 unmatched bits");
    check(sym_valid == 1'b0, "R5", sym_valid, 0, "no symbol with error");
    @(negedge clk);
    err_allow = 1'b0;
    check(dec_err == 1'b0, "R5", dec_err, 0, "error one cycle only");
    check(bit_ready == 1'b1, "R5", bit_ready, 1, "ready after error");
    send_sym(3, 0);
    drain();

    // Random tables, one free code kept at every length
    for (int t = 0; t < 2; t++) begin
      code = 0; total = 0;
      for (int l = 1; l <= 16; l++) begin
        code = code << 1;
        avail = (1 << l) - code - 1;
        c = int'($urandom % 4);
        if (c > avail) c = avail;
        if (total + c > 200) c = 0;
        if (l == 16 && total == 0) c = 1;
        cnt[l] = c; total += c; code += c;
      end
      build_table();
      load_table();
      random_stream(150, 2);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule